// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Serializer

This block turns a stereo pair of 16-bit audio samples into a single-wire consumer digital-audio bitstream, one frame per sampling period. Each frame carries the left subframe first, then the right one. Each subframe has 32 time slots: a 4-slot sync preamble, 8 forced-zero slots, the 16 audio bits least significant first, and then the validity, user, channel-status and parity slots. Every slot is split into two half-bit cells and sent with biphase-mark coding. The preambles deliberately break that coding, so a receiver can find the frame and subframe boundaries.

The block is paced by a cell enable, which pulses once per half-bit cell at 128 times the frame rate. A half-rate input lets the same enable serve a 24 kHz stream as well as a 48 kHz one: the block then spends two enable pulses on each cell. Samples are offered on a strobe interface at any point in a frame. They are held and take effect at the next frame boundary. A block-start input forces the next left subframe to open a new 192-frame channel-status block.

Top module: `bmc_audio_tx`

## Requirements
- R1: A frame lasts 128 cells: cells 0 to 63 form the left subframe and cells 64 to 127 form the right subframe. Within a subframe, slot n occupies cells 2n and 2n+1.
- R2: Slots 0 to 3 of a subframe carry an 8-cell preamble, most significant bit first. The patterns are 11101000 for the left subframe that opens a block, 11100010 for every other left subframe, and 11100100 for every right subframe. A pattern is inverted when the cell before it was high.
- R3: In slots 4 to 31, the line level changes at the start of every slot.
- R4: Slots 4 to 11 carry zero: the line keeps its level through the middle of the slot.
- R5: Slots 12 to 27 carry the audio sample, bit 0 in slot 12 up to bit 15 in slot 27. A one bit toggles the line in the middle of its slot, and a zero bit does not.
- R6: Slot 28 carries validity (aux bit 2), slot 29 user data (aux bit 1) and slot 30 channel status (aux bit 0). Slot 31 carries parity.
- R7: The parity slot makes slots 4 to 31 hold an even number of ones, so the line is low at the last cell of every subframe.
- R8: A strobe loads the samples and aux bits into a holding stage. The frame in progress keeps its data. The values held at the frame boundary are used for the whole next frame, and when two strobes arrive in one frame, the later one wins.
- R9: A frame counter counts frames of 192. The left preamble of the first frame of each count uses the block-opening pattern. A block-start pulse restarts the count, so the next frame opens a block.
- R10: With half_rate high, a cell advances on every second cell_en pulse, and the line holds on the pulses in between.
- R11: Without an advancing cell_en, the line output does not change.
- R12: Under reset the line is low. The first frame after reset opens a block and carries all-zero samples and aux bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cell_en | input | 1 | One pulse per half-bit cell (128 per frame at full rate) |
| half_rate | input | 1 | High: each cell takes two cell_en pulses |
| smp_stb | input | 1 | Loads samples and aux bits into the holding stage |
| smp_left | input | 16 | Left audio sample |
| smp_right | input | 16 | Right audio sample |
| aux_left | input | 3 | Left {validity, user, channel status} |
| aux_right | input | 3 | Right {validity, user, channel status} |
| blk_start | input | 1 | Next frame opens a new 192-frame block |
| line_out | output | 1 | Biphase-mark coded serial output |

## Verification
The bench compares every cell against frames it builds arithmetically. It uses all-zero and all-one samples, single set bits at opposite ends of the two channels, alternating patterns, and a run of arithmetically spread values. These patterns show whether bits are in the wrong order or whether left and right are swapped, and the aux values show whether the three flag bits are in the wrong place. Frames with two strobes, or with a strobe in the middle of the frame, show whether the sample is taken at the frame boundary or at the strobe. The bench also runs gapped enables, half rate, and a full 192-frame run after a block-start pulse. These show whether the block counts enable pulses correctly and where the block-opening preamble falls.

// File: rtl/bmc_tx_pkg.sv
// Shared constants and types for the biphase-mark audio serializer.
// Assumes a 4-slot preamble and a 4-slot trailing flag field per subframe.
package bmc_tx_pkg;
    localparam logic [7:0] PRE_BLOCK = 8'b11101000;
    localparam logic [7:0] PRE_LEFT  = 8'b11100010;
    localparam logic [7:0] PRE_RIGHT = 8'b11100100;
    localparam int PRE_SLOTS  = 4;
    localparam int FLAG_SLOTS = 4;

    typedef enum logic [1:0] {
        SK_PRE,
        SK_PAD,
        SK_AUD,
        SK_FLG
    } slot_kind_e;

    typedef struct packed {
        logic vld;
        logic usr;
        logic cst;
    } aux_t;
endpackage

// File: rtl/bmc_cell_timer.sv
// Cell pacing: turns cell_en (and half_rate) into an advance tick, and
// counts the cells of a frame. Assumes CELLS is a power of two.
module bmc_cell_timer #(
    parameter int CELLS = 128,
    localparam int CW   = $clog2(CELLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cell_en,
    input  logic          half_rate,
    output logic          tick,
    output logic          frame_wrap,
    output logic [CW-1:0] cell_idx
);
    logic          phase_q;
    logic [CW-1:0] idx_q;

    assign tick       = cell_en & (~half_rate | phase_q);
    assign frame_wrap = tick & (idx_q == CW'(CELLS - 1));
    assign cell_idx   = idx_q;

    // Half-rate phase: alternate on enables, cleared at full rate.
    always_ff @(posedge clk) begin
        if (!rst_n)          phase_q <= 1'b0;
        else if (!half_rate) phase_q <= 1'b0;
        else if (cell_en)    phase_q <= ~phase_q;
    end

    // Cell counter: step on every tick, wrap at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)          idx_q <= '0;
        else if (frame_wrap) idx_q <= '0;
        else if (tick)       idx_q <= idx_q + 1'b1;
    end
endmodule

// File: rtl/bmc_frame_seq.sv
// Frame content: holds and activates samples, counts the frames of a
// block, and decodes the current cell into a preamble pattern/position or
// a data slot bit. Assumes the slot count is a power of two.
module bmc_frame_seq
    import bmc_tx_pkg::*;
#(
    parameter int SAMPLE_W     = 16,
    parameter int PAD_SLOTS    = 8,
    parameter int BLOCK_FRAMES = 192,
    parameter int CW           = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_wrap,
    input  logic [CW-1:0]       cell_idx,
    input  logic                smp_stb,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic [2:0]          aux_left,
    input  logic [2:0]          aux_right,
    input  logic                blk_start,
    output logic                in_pre,
    output logic [7:0]          pre_pat,
    output logic [2:0]          pre_pos,
    output logic                slot_bit
);
    localparam int SLOTS  = PRE_SLOTS + PAD_SLOTS + SAMPLE_W + FLAG_SLOTS;
    localparam int SW     = $clog2(SLOTS);
    localparam int AW     = $clog2(SAMPLE_W);
    localparam int AUD_LO = PRE_SLOTS + PAD_SLOTS;
    localparam int FLG_LO = AUD_LO + SAMPLE_W;
    localparam int FCW    = $clog2(BLOCK_FRAMES);

    logic [1:0][SAMPLE_W-1:0] in_s;
    logic [1:0][2:0]          in_a;
    logic [1:0][SAMPLE_W-1:0] act_s;
    logic [1:0][2:0]          act_a;

    assign in_s = {smp_right, smp_left};
    assign in_a = {aux_right, aux_left};

    // One hold/active register pair for each channel.
    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        logic [SAMPLE_W-1:0] hold_s, live_s;
        logic [2:0]          hold_a, live_a;

        // Holding stage: capture on every strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_s <= '0;
                hold_a <= '0;
            end else if (smp_stb) begin
                hold_s <= in_s[ch];
                hold_a <= in_a[ch];
            end
        end

        // Active stage: take the held values at the frame boundary.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_s <= '0;
                live_a <= '0;
            end else if (frame_wrap) begin
                live_s <= hold_s;
                live_a <= hold_a;
            end
        end

        assign act_s[ch] = live_s;
        assign act_a[ch] = live_a;
    end

    logic           restart_q;
    logic           is_block_q;
    logic [FCW-1:0] frame_q;
    logic [FCW-1:0] frame_nxt;

    // Next frame number: restart on request, otherwise wrap at the block size.
    always_comb begin
        if (restart_q || blk_start)           frame_nxt = '0;
        else if (frame_q == FCW'(BLOCK_FRAMES - 1)) frame_nxt = '0;
        else                                  frame_nxt = frame_q + 1'b1;
    end

    // Block-start request: remember it until the next frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)          restart_q <= 1'b0;
        else if (frame_wrap) restart_q <= 1'b0;
        else if (blk_start)  restart_q <= 1'b1;
    end

    // Frame counter and block-opening flag, updated at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q    <= '0;
            is_block_q <= 1'b1;
        end else if (frame_wrap) begin
            frame_q    <= frame_nxt;
            is_block_q <= (frame_nxt == '0);
        end
    end

    logic                sub_sel;
    logic [SW-1:0]       slot;
    logic                half;
    logic [SW-1:0]       aoff;
    logic [SAMPLE_W-1:0] cur_s;
    aux_t                cur_a;
    logic                parity;
    slot_kind_e          kind;

    assign sub_sel = cell_idx[CW-1];
    assign slot    = cell_idx[CW-2:1];
    assign half    = cell_idx[0];
    assign aoff    = slot - SW'(AUD_LO);
    assign cur_s   = act_s[sub_sel];
    assign cur_a   = aux_t'(act_a[sub_sel]);
    assign parity  = ^cur_s ^ cur_a.vld ^ cur_a.usr ^ cur_a.cst;

    // Slot classification from the slot number.
    always_comb begin
        if (slot < SW'(PRE_SLOTS))   kind = SK_PRE;
        else if (slot < SW'(AUD_LO)) kind = SK_PAD;
        else if (slot < SW'(FLG_LO)) kind = SK_AUD;
        else                         kind = SK_FLG;
    end

    // Bit carried by the current data slot.
    always_comb begin
        case (kind)
            SK_AUD:  slot_bit = cur_s[aoff[AW-1:0]];
            SK_FLG: begin
                case (slot - SW'(FLG_LO))
                    SW'(0):  slot_bit = cur_a.vld;
                    SW'(1):  slot_bit = cur_a.usr;
                    SW'(2):  slot_bit = cur_a.cst;
                    default: slot_bit = parity;
                endcase
            end
            default: slot_bit = 1'b0;
        endcase
    end

    // Preamble selection and cell position inside the preamble.
    always_comb begin
        in_pre  = (kind == SK_PRE);
        pre_pos = {slot[1:0], half};
        if (sub_sel)         pre_pat = PRE_RIGHT;
        else if (is_block_q) pre_pat = PRE_BLOCK;
        else                 pre_pat = PRE_LEFT;
    end
endmodule

// File: rtl/bmc_line_encoder.sv
// Line coder: drives the output level cell by cell, with a biphase-mark
// toggle per slot plus a mid-slot toggle for ones, and preamble cells that
// follow the pattern, inverted when the line before the preamble was high.
module bmc_line_encoder (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       in_pre,
    input  logic [7:0] pre_pat,
    input  logic [2:0] pre_pos,
    input  logic       half,
    input  logic       slot_bit,
    output logic       line
);
    logic line_q;
    logic pol_q;
    logic base;
    logic lvl_nxt;

    assign line = line_q;
    assign base = (pre_pos == 3'd0) ? line_q : pol_q;

    // Next cell level.
    always_comb begin
        if (in_pre)     lvl_nxt = pre_pat[3'd7 - pre_pos] ^ base;
        else if (!half) lvl_nxt = ~line_q;
        else            lvl_nxt = line_q ^ slot_bit;
    end

    // Output register: advance one cell per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    line_q <= 1'b0;
        else if (tick) line_q <= lvl_nxt;
    end

    // Preamble polarity: the level seen just before the first preamble cell.
    always_ff @(posedge clk) begin
        if (!rst_n)                              pol_q <= 1'b0;
        else if (tick && in_pre && pre_pos == 3'd0) pol_q <= line_q;
    end
endmodule

// File: rtl/bmc_audio_tx.sv
// Top of the biphase-mark stereo serializer: pacing, frame content and line
// coder. Assumes cell_en pulses at 128x the frame rate (twice that with
// half_rate set) and that samples arrive at least once per frame.
module bmc_audio_tx #(
    parameter int SAMPLE_W     = 16,
    parameter int PAD_SLOTS    = 8,
    parameter int BLOCK_FRAMES = 192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cell_en,
    input  logic                half_rate,
    input  logic                smp_stb,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic [2:0]          aux_left,
    input  logic [2:0]          aux_right,
    input  logic                blk_start,
    output logic                line_out
);
    localparam int SLOTS = bmc_tx_pkg::PRE_SLOTS + PAD_SLOTS + SAMPLE_W
                           + bmc_tx_pkg::FLAG_SLOTS;
    localparam int CELLS = 4 * SLOTS;
    localparam int CW    = $clog2(CELLS);

    logic          tick;
    logic          frame_wrap;
    logic [CW-1:0] cell_idx;
    logic          in_pre;
    logic [7:0]    pre_pat;
    logic [2:0]    pre_pos;
    logic          slot_bit;

    bmc_cell_timer #(.CELLS(CELLS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_en    (cell_en),
        .half_rate  (half_rate),
        .tick       (tick),
        .frame_wrap (frame_wrap),
        .cell_idx   (cell_idx)
    );

    bmc_frame_seq #(
        .SAMPLE_W     (SAMPLE_W),
        .PAD_SLOTS    (PAD_SLOTS),
        .BLOCK_FRAMES (BLOCK_FRAMES),
        .CW           (CW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_wrap (frame_wrap),
        .cell_idx   (cell_idx),
        .smp_stb    (smp_stb),
        .smp_left   (smp_left),
        .smp_right  (smp_right),
        .aux_left   (aux_left),
        .aux_right  (aux_right),
        .blk_start  (blk_start),
        .in_pre     (in_pre),
        .pre_pat    (pre_pat),
        .pre_pos    (pre_pos),
        .slot_bit   (slot_bit)
    );

    bmc_line_encoder u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .in_pre   (in_pre),
        .pre_pat  (pre_pat),
        .pre_pos  (pre_pos),
        .half     (cell_idx[0]),
        .slot_bit (slot_bit),
        .line     (line_out)
    );
endmodule

// File: rtl/bmc_audio_tx_chk.sv
// Protocol checker for bmc_audio_tx, attached by bind. Watches the cell
// pacing, the preamble selection and the coded line.
module bmc_audio_tx_chk #(
    parameter int CW        = 7,
    parameter int PAD_SLOTS = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          half_rate,
    input logic          tick,
    input logic [CW-1:0] cell_idx,
    input logic          in_pre,
    input logic [7:0]    pre_pat,
    input logic          line_out
);
    logic [CW-2:0] slot;
    logic          pad_slot;

    assign slot     = cell_idx[CW-1:1] & {(CW-1){1'b1}};
    assign pad_slot = (slot >= (CW-1)'(4)) && (slot < (CW-1)'(4 + PAD_SLOTS));

    assert_slot_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !in_pre && !cell_idx[0]) |=> (line_out != $past(line_out)));

    assert_pad_flat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pad_slot && cell_idx[0]) |=> (line_out == $past(line_out)));

    assert_sub_end_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&cell_idx[CW-2:0])) |=> !line_out);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(line_out));

    assert_half_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && half_rate) |=> (!tick || !half_rate));

    assert_right_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pre && cell_idx[CW-1]) |-> (pre_pat == 8'b11100100));

    assert_pre_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_pre |-> (pre_pat[7:5] == 3'b111 && $countones(pre_pat) == 4));
endmodule

bind bmc_audio_tx bmc_audio_tx_chk #(.CW(CW), .PAD_SLOTS(PAD_SLOTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_rate (half_rate),
    .tick      (tick),
    .cell_idx  (cell_idx),
    .in_pre    (in_pre),
    .pre_pat   (pre_pat),
    .line_out  (line_out)
);

// File: tb/bmc_audio_tx_tb.sv
`timescale 1ns/1ps
module bmc_audio_tx_tb;
    logic        clk = 1'b0;
    logic        rst_n, cell_en, half_rate, smp_stb, blk_start;
    logic [15:0] smp_left, smp_right;
    logic [2:0]  aux_left, aux_right;
    logic        line_out;

    always #2.5 clk = ~clk;

    bmc_audio_tx u_dut (
        .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .half_rate(half_rate),
        .smp_stb(smp_stb), .smp_left(smp_left), .smp_right(smp_right),
        .aux_left(aux_left), .aux_right(aux_right), .blk_start(blk_start),
        .line_out(line_out)
    );

    int total = 0;
    int bad   = 0;

    // Bench model state
    logic [15:0] h_l = '0, h_r = '0, a_l = '0, a_r = '0;
    logic [2:0]  hx_l = '0, hx_r = '0, ax_l = '0, ax_r = '0;
    int          m_fc = 0;
    bit          m_flag = 0;
    bit          m_isb = 1;
    logic        m_lvl = 1'b0;
    logic        exp_c [128];
    logic        prev;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic logic [37:0] pat(input int i);
        logic [15:0] l, r;
        logic [2:0]  xl, xr;
        case (i)
            0: begin l = 16'h0000; r = 16'h0000; xl = 3'b000; xr = 3'b000; end
            1: begin l = 16'hFFFF; r = 16'hFFFF; xl = 3'b111; xr = 3'b111; end
            2: begin l = 16'h0001; r = 16'h8000; xl = 3'b100; xr = 3'b001; end
            3: begin l = 16'hA5A5; r = 16'h5A5A; xl = 3'b010; xr = 3'b101; end
            default: begin
                l  = 16'(i * 40503 + 17);
                r  = 16'(i * 26417) ^ 16'h3C3C;
                xl = 3'(i);
                xr = 3'(i >> 1);
            end
        endcase
        return {l, r, xl, xr};
    endfunction

    // Expected cell levels for one frame, from the slot layout.
    task automatic build_frame();
        logic        lvl = m_lvl;
        logic [7:0]  pp;
        logic [31:0] sv;
        logic [15:0] s;
        logic [2:0]  x;
        for (int sf = 0; sf < 2; sf++) begin
            s  = sf ? a_r : a_l;
            x  = sf ? ax_r : ax_l;
            sv = '0;
            for (int k = 0; k < 16; k++) sv[12 + k] = s[k];
            sv[28] = x[2];
            sv[29] = x[1];
            sv[30] = x[0];
            sv[31] = 1'(($countones(s) + $countones(x)) % 2);
            pp = sf ? 8'hE4 : (m_isb ? 8'hE8 : 8'hE2);
            for (int j = 0; j < 8; j++) exp_c[sf * 64 + j] = pp[7 - j] ^ lvl;
            lvl = exp_c[sf * 64 + 7];
            for (int sl = 4; sl < 32; sl++) begin
                lvl = ~lvl;
                exp_c[sf * 64 + 2 * sl] = lvl;
                if (sv[sl]) lvl = ~lvl;
                exp_c[sf * 64 + 2 * sl + 1] = lvl;
            end
        end
    endtask

    function automatic string cell_tag(input int c);
        int sl = (c % 64) / 2;
        if (sl < 4)      return "R2";
        if (c % 2 == 0)  return "R3";
        if (sl < 12)     return "R4";
        if (sl < 28)     return "R5";
        return "R6";
    endfunction

    task automatic drive_stb(input int i);
        logic [37:0] p = pat(i);
        smp_stb = 1'b1;
        {smp_left, smp_right, aux_left, aux_right} = p;
        {h_l, h_r, hx_l, hx_r} = p;
    endtask

    // One cell: mode 0 plain, 1 with idle gaps, 2 half rate.
    task automatic do_cell(input int mode, input int c);
        if (mode == 2) begin
            cell_en = 1'b1;
            @(negedge clk);
            smp_stb = 1'b0; blk_start = 1'b0;
            check(line_out == prev, "R10", "half-rate in-between hold", line_out, prev);
            @(negedge clk);
        end else if (mode == 1 && c % 3 == 1) begin
            cell_en = 1'b0;
            @(negedge clk);
            smp_stb = 1'b0; blk_start = 1'b0;
            check(line_out == prev, "R11", "idle hold", line_out, prev);
            cell_en = 1'b1;
            @(negedge clk);
        end else begin
            cell_en = 1'b1;
            @(negedge clk);
            smp_stb = 1'b0; blk_start = 1'b0;
        end
    endtask

    task automatic run_frame(input int mode, input int sa, input int sb,
                             input bit blk, input string tag);
        bit fok = 1;
        half_rate = (mode == 2);
        build_frame();
        prev = m_lvl;
        for (int c = 0; c < 128; c++) begin
            if (c == 40 && sa >= 0) drive_stb(sa);
            if (c == 90 && sb >= 0) drive_stb(sb);
            if (c == 50 && blk) begin blk_start = 1'b1; m_flag = 1; end
            do_cell(mode, c);
            check(line_out == exp_c[c], cell_tag(c), $sformatf("cell %0d", c),
                  line_out, exp_c[c]);
            if (line_out != exp_c[c]) fok = 0;
            if (c == 63 || c == 127)
                check(line_out == 1'b0, "R7", "subframe ends low", line_out, 0);
            prev = exp_c[c];
        end
        check(fok, tag, "frame match", fok, 1);
        // Frame boundary model (R8, R9)
        {a_l, a_r, ax_l, ax_r} = {h_l, h_r, hx_l, hx_r};
        m_fc   = m_flag ? 0 : ((m_fc == 191) ? 0 : m_fc + 1);
        m_flag = 0;
        m_isb  = (m_fc == 0);
        m_lvl  = exp_c[127];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int nb;
        rst_n = 1'b0; cell_en = 1'b1; half_rate = 1'b0; smp_stb = 1'b0;
        blk_start = 1'b0; smp_left = '0; smp_right = '0;
        aux_left = '0; aux_right = '0;
        repeat (3) begin
            @(negedge clk);
            check(line_out == 1'b0, "R12", "reset level", line_out, 0);
        end
        cell_en = 1'b0;
        rst_n   = 1'b1;
        run_frame(0, 1, -1, 0, "R12");   // first frame: block start, zero data
        run_frame(0, 2, -1, 0, "R5");
        run_frame(0, 3, -1, 0, "R6");
        run_frame(0, 4, 5, 0, "R8");     // two strobes: later one must win
        for (int i = 6; i < 13; i++) run_frame(0, i, -1, 0, "R1");
        run_frame(1, 13, -1, 0, "R11");
        run_frame(2, 14, -1, 0, "R10");
        run_frame(2, -1, -1, 0, "R10");
        run_frame(0, -1, -1, 1, "R9");   // block-start request
        nb = 0;
        for (int f = 0; f < 193; f++) begin
            if (m_isb) nb++;
            run_frame(0, (f % 40 == 0) ? 20 + f : -1, -1, 0, "R9");
        end
        // R9: block opens right after the request and again 192 frames later
        check(nb == 2, "R9", "block-opening frames in 193", nb, 2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule